// File: doc/BRIEF.md
# Dual-Channel Gain Serial Master

This block drives an external digital variable-gain amplifier over a write-only SPI link. A start strobe launches one fixed 12-bit frame that carries a 6-bit gain for receive channel A and a 6-bit gain for receive channel B. The swap input picks which channel's field is sent first. Each field is sent most significant bit first.

The serial clock is taken from the sample-rate clock. The sample clock is divided by 8 and then by an 11-bit factor. The factor arrives as a low 8-bit part and a high 3-bit part, and a factor of 0 acts as 1. The controlling logic must choose a factor that keeps the serial clock below 25 MHz. The gains, the swap bit and the factor are captured when a start is accepted, so software may change them while a frame is in flight. A start that arrives during a frame is dropped.

The sequencer has five states. `ST_IDLE` has chip select high and the clock low. An accepted start moves it to `ST_LEAD`, which holds chip select low for one half-period. The first tick moves it to `ST_HIGH`, which drives the clock high. A tick in `ST_HIGH` moves it to `ST_LOW` and shifts out the next bit. On the last bit it goes to `ST_TRAIL` instead. A tick in `ST_LOW` returns it to `ST_HIGH`. A tick in `ST_TRAIL` returns it to `ST_IDLE`.

Top module: `gain_spi_master`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `spi_mosi` is 0 and `busy` is 0. The stored divide factor resets to 5.
- R2: With `swap` = 0, the 12 bits sampled on the rising edges of `spi_sclk` are `gain_a` followed by `gain_b`, each sent MSB first.
- R3: With `swap` = 1, the 12 sampled bits are `gain_b` followed by `gain_a`, each sent MSB first.
- R4: Each high and each low phase of `spi_sclk` lasts 4*D cycles of `clk`. D is the factor {`div_hi`,`div_lo`}, with `div_hi` as bits 10..8. One full serial period is therefore 8*D cycles.
- R5: A factor of 0 gives the same timing as a factor of 1.
- R6: `spi_cs_n` falls one half-period (4*D cycles) before the first rising edge of `spi_sclk`. It rises one half-period after the falling edge that ends the 12th bit. `spi_mosi` changes only while `spi_sclk` is low.
- R7: `busy` is 1 from the first clock edge after an accepted start until `spi_cs_n` returns high. A frame keeps `busy` high for 100*D cycles.
- R8: A `start` pulse while `busy` is 1 is ignored. The frame in flight and its length are unchanged.
- R9: The gains, `swap` and the factor are captured at the accepted start. Changes to them during the frame do not affect that frame.
- R10: `spi_sclk` is 0 whenever `spi_cs_n` is 1.
- R11: Each frame has exactly 12 rising edges of `spi_sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to send a frame |
| gain_a | input | 6 | Gain for channel A |
| gain_b | input | 6 | Gain for channel B |
| swap | input | 1 | 0: A first, 1: B first |
| div_lo | input | 8 | Divide factor bits 7..0 |
| div_hi | input | 3 | Divide factor bits 10..8 |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data, MSB first |
| spi_cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Frame in progress |

## Verification
The assertions rely on the divide limit held in the ticker never being below 4. This holds because a zero factor is replaced by 1 before it is stored. They also rely on `start` being sampled only in `ST_IDLE`, so the shift counter cannot reload in mid-frame. The stimulus drives every input half a cycle after a rising clock edge. It picks factors of 0 to 300, so the slowest frame still fits in the run. It also raises `start` and changes all other inputs during one frame, to exercise the ignore and capture paths without breaking those assumptions.

// File: rtl/gain_spi_pkg.sv
package gain_spi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TRAIL
    } spi_state_t;

    localparam int RESET_FACTOR = 5;

endpackage

// File: rtl/gain_spi_ticker.sv
module gain_spi_ticker #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         tick
);

    logic [W-1:0] cnt_q;
    logic         at_end;

    assign at_end = (cnt_q == limit - W'(1));
    assign tick   = run && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    // R4: the half-period counter never runs past its limit
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < limit));

endmodule

// File: rtl/gain_spi_shifter.sv
module gain_spi_shifter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] data,
    input  logic         advance,
    output logic         dout,
    output logic         last
);

    localparam int CW = $clog2(W);

    logic [W-1:0]  sr_q;
    logic [CW-1:0] idx_q;

    assign dout = sr_q[W-1];
    assign last = (idx_q == CW'(W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sr_q  <= data;
            idx_q <= '0;
        end else if (advance) begin
            sr_q  <= {sr_q[W-2:0], 1'b0};
            idx_q <= idx_q + CW'(1);
        end
    end

    // R11: the bit index never passes the final bit of the frame
    p_bit_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= CW'(W - 1));

    // R11: no shift is requested once the final bit is out
    p_no_overshift_r11: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> !advance);

endmodule

// File: rtl/gain_spi_master.sv
module gain_spi_master
    import gain_spi_pkg::*;
#(
    parameter int GAIN_W   = 6,
    parameter int DIV_W    = 11,
    parameter int DIV_LO_W = 8,
    parameter int PRE_DIV  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [GAIN_W-1:0]         gain_a,
    input  logic [GAIN_W-1:0]         gain_b,
    input  logic                      swap,
    input  logic [DIV_LO_W-1:0]       div_lo,
    input  logic [DIV_W-DIV_LO_W-1:0] div_hi,
    output logic                      spi_sclk,
    output logic                      spi_mosi,
    output logic                      spi_cs_n,
    output logic                      busy
);

    localparam int FRAME_W    = 2 * GAIN_W;
    localparam int HALF_SHIFT = $clog2(PRE_DIV) - 1;
    localparam int HALF_W     = DIV_W + HALF_SHIFT;

    spi_state_t         state_q, state_d;
    logic [DIV_W-1:0]   div_req, div_eff;
    logic [HALF_W-1:0]  half_d, half_q;
    logic [FRAME_W-1:0] frame_d;
    logic               accept, tick, last_bit, shift_en, run;

    // Request decode: a zero factor is replaced by one
    assign div_req = {div_hi, div_lo};
    assign div_eff = (div_req == '0) ? DIV_W'(1) : div_req;
    assign half_d  = {div_eff, {HALF_SHIFT{1'b0}}};

    // Field order chosen by the swap input
    always_comb begin
        if (swap) begin
            frame_d = {gain_b, gain_a};
        end else begin
            frame_d = {gain_a, gain_b};
        end
    end

    assign accept   = start && (state_q == ST_IDLE);
    assign run      = (state_q != ST_IDLE);
    assign shift_en = (state_q == ST_HIGH) && tick && !last_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= HALF_W'(RESET_FACTOR) << HALF_SHIFT;
        end else if (accept) begin
            half_q <= half_d;
        end
    end

    gain_spi_ticker #(.W(HALF_W)) u_ticker (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .limit (half_q),
        .tick  (tick)
    );

    gain_spi_shifter #(.W(FRAME_W)) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .data    (frame_d),
        .advance (shift_en),
        .dout    (spi_mosi),
        .last    (last_bit)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_LEAD;
            ST_LEAD:  if (tick)   state_d = ST_HIGH;
            ST_HIGH:  if (tick)   state_d = last_bit ? ST_TRAIL : ST_LOW;
            ST_LOW:   if (tick)   state_d = ST_HIGH;
            ST_TRAIL: if (tick)   state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Moore outputs decoded from the registered state
    always_comb begin
        spi_sclk = 1'b0;
        spi_cs_n = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                spi_cs_n = 1'b1;
                busy     = 1'b0;
            end
            ST_HIGH:  spi_sclk = 1'b1;
            ST_LEAD,
            ST_LOW,
            ST_TRAIL: spi_sclk = 1'b0;
            default: begin
                spi_cs_n = 1'b1;
                busy     = 1'b0;
            end
        endcase
    end

    // R10: the clock stays low while chip select is inactive
    p_sclk_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R6: data holds steady while the clock is high
    p_mosi_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> $stable(spi_mosi));

    // R6: chip select falls with the clock low
    p_cs_fall_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> !spi_sclk);

    // R6: chip select rises only after a low clock phase
    p_cs_rise_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> !$past(spi_sclk));

    // R8: a start during a frame does not end or restart it
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !tick) |=> (busy && $stable(half_q)));

endmodule

// File: tb/gain_spi_master_test.sv
module gain_spi_master_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [5:0] gain_a = '0;
    logic [5:0] gain_b = '0;
    logic       swap = 1'b0;
    logic [7:0] div_lo = '0;
    logic [2:0] div_hi = '0;
    logic       spi_sclk, spi_mosi, spi_cs_n, busy;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // monitor state
    int          rises, hi_len, lead_len, trail_len, busy_len, idle_err;
    logic [11:0] bits;
    logic        prev_sclk = 1'b0;

    // {gain_a, gain_b, swap, factor}
    localparam logic [23:0] VEC [0:7] = '{
        {6'h2A, 6'h15, 1'b0, 11'd5},
        {6'h2A, 6'h15, 1'b1, 11'd5},
        {6'h3F, 6'h00, 1'b0, 11'd1},
        {6'h01, 6'h20, 1'b1, 11'd0},
        {6'h13, 6'h2C, 1'b0, 11'd3},
        {6'h00, 6'h3F, 1'b1, 11'd2},
        {6'h24, 6'h09, 1'b1, 11'd7},
        {6'h11, 6'h22, 1'b0, 11'd300}
    };

    gain_spi_master uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .gain_a(gain_a), .gain_b(gain_b), .swap(swap),
        .div_lo(div_lo), .div_hi(div_hi),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .busy(busy)
    );

    always #10 clk = ~clk;

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
            summary();
            $finish;
        end
    end

    always @(negedge clk) begin
        if (spi_sclk && !prev_sclk) begin
            rises = rises + 1;
            bits  = {bits[10:0], spi_mosi};
        end
        if (spi_sclk && rises == 1) hi_len = hi_len + 1;
        if (!spi_cs_n && !spi_sclk && rises == 0) lead_len = lead_len + 1;
        if (!spi_cs_n && !spi_sclk && rises == 12) trail_len = trail_len + 1;
        if (busy) busy_len = busy_len + 1;
        if (spi_cs_n && spi_sclk) idle_err = idle_err + 1;
        prev_sclk = spi_sclk;
    end

    task automatic check(string tag, int act, int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic run_frame(input logic [5:0] ga, input logic [5:0] gb,
                             input logic sw, input logic [10:0] f, input bit disturb);
        int d;
        int exp_frame;
        d = (f == 0) ? 1 : int'(f);
        exp_frame = sw ? int'({gb, ga}) : int'({ga, gb});
        @(posedge clk); #1;
        rises = 0; hi_len = 0; lead_len = 0; trail_len = 0;
        busy_len = 0; idle_err = 0; bits = '0;
        gain_a = ga; gain_b = gb; swap = sw;
        div_lo = f[7:0]; div_hi = f[10:8];
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (disturb) begin
            repeat (30) @(posedge clk);
            #1;
            // R9: change every captured input mid-frame
            gain_a = ~ga; gain_b = ~gb; swap = ~sw;
            div_lo = 8'd9; div_hi = 3'd0;
            // R8: start while busy
            start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
        end
        wait (busy == 1'b0);
        @(negedge clk);
        check(sw ? "R3 frame B-first" : "R2 frame A-first", int'(bits), exp_frame);
        check("R11 rising edges", rises, 12);
        check("R4 high phase", hi_len, 4 * d);
        check("R6 lead time", lead_len, 4 * d);
        check("R6 trail time", trail_len, 4 * d);
        check("R7 busy length", busy_len, 100 * d);
        check("R10 sclk idle", idle_err, 0);
        if (f == 0) check("R5 zero factor", hi_len, 4);
        if (disturb) begin
            check("R8 ignored start busy", busy_len, 100 * d);
            check("R9 captured frame", int'(bits), exp_frame);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        // R1: outputs while reset is held
        check("R1 cs_n", int'(spi_cs_n), 1);
        check("R1 sclk", int'(spi_sclk), 0);
        check("R1 mosi", int'(spi_mosi), 0);
        check("R1 busy", int'(busy), 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        for (int i = 0; i < 8; i++) begin
            run_frame(VEC[i][23:18], VEC[i][17:12], VEC[i][11], VEC[i][10:0], 1'b0);
        end

        // R8 and R9 directed: disturb during a frame
        run_frame(6'h35, 6'h0A, 1'b0, 11'd4, 1'b1);
        run_frame(6'h07, 6'h38, 1'b1, 11'd3, 1'b1);
        // a normal frame follows an ignored start
        run_frame(6'h2F, 6'h10, 1'b0, 11'd2, 1'b0);

        // R10: idle after frames with no start
        repeat (50) @(negedge clk);
        check("R10 idle cs_n", int'(spi_cs_n), 1);
        check("R10 idle sclk", int'(spi_sclk), 0);

        // R1: reset factor of 5 applies when no factor was ever accepted
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        @(negedge clk);
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset cs_n", int'(spi_cs_n), 1);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        summary();
        $finish;
    end

endmodule